// File: doc/BRIEF.md
# Parallel Camera Capture Front End

This block takes the raw signals of a parallel image sensor (pixel clock, horizontal sync, vertical sync and a pixel data bus of up to 14 bits) and turns the pixels of selected frames into 32-bit words in a small output FIFO that a bus reader drains. All of its logic runs on the system clock. The pixel clock is treated as a slow signal: it is registered once with the syncs and the data, and a sampling strobe is formed from the chosen transition.

Frame timing follows the sync lines. Vertical sync active means vertical blanking. A frame starts at the first sampled edge where vertical sync is inactive, and ends at the first sampled edge where it is active again. Horizontal sync active means line blanking. A pixel is a sample taken while both syncs are inactive. Sensors put at least one line-blanking sample before the first line, so the frame start sample carries no pixel. Packing restarts at every frame start, and a partly filled word left at frame end is dropped.

Software-facing settings arrive as plain inputs. These are enable, arm and disarm pulses, single-shot or continuous mode, sampling edge, sync polarities, frame decimation, data width and a crop window. Sticky event flags with a write-one clear and a masked interrupt summarise what happened.

Top module: `cam_capture`

## Requirements
- R1: With cfg_pclk_fall=0 the pins are sampled on rising pix_clk transitions; with cfg_pclk_fall=1 on falling ones. Data present only around the other transition is never stored.
- R2: cfg_hs_high/cfg_vs_high set to 1 make the sync active high, and 0 makes it active low. stat_hs/stat_vs show 1 while the sync is active, one clk edge after the pin changes, with no pixel clock needed.
- R3: Capture arms when cap_req pulses (cap_clr wins if both pulse). It takes effect only at the next frame start while cfg_enable=1, so pixels of a frame already running when cap_req pulses are not stored.
- R4: With cfg_snapshot=0, capture_on stays 1 across frames and every selected frame is stored.
- R5: With cfg_snapshot=1, exactly one frame is stored; capture_on drops to 0 at the end of that frame, and later frames are not stored.
- R6: cfg_rate selects decimation: 0 (or 3) stores all frames, 1 stores the 1st, 3rd, 5th, and so on, and 2 stores the 1st, 5th, 9th, and so on. Frames are counted from the first frame start after arming.
- R7: cfg_width=0 (8-bit bus) packs four samples per word, the first in bits 7:0 and the fourth in bits 31:24.
- R8: cfg_width=1, 2 or 3 (10, 12 or 14 bits) packs two samples per word, the first in bits 15:0. Each sample is cut to the selected width and zero-extended to 16 bits.
- R9: With cfg_crop_en=1, only pixels with crop_x <= column < crop_x+crop_w and crop_y <= line < crop_y+crop_h are stored. Column counts pixels from 0 within a line, line counts lines from 0 within a frame, and both restart at frame start.
- R10: The FIFO returns words in arrival order. rd_data shows the oldest word while fifo_valid=1, and rd_en with fifo_valid=1 removes it.
- R11: A word arriving while the FIFO holds FIFO_DEPTH words is dropped, flags[3] is set, and the stored words stay unchanged.
- R12: flags bits: 0 end of a stored frame, 1 end of a line inside a stored frame (hsync turns active), 2 frame start while enabled, 3 overrun. A set bit stays until a 1 is written to the same flag_clr bit; a new event wins over a clear.
- R13: irq is 1 exactly when some bit is set in both flags and irq_en.
- R14: With cfg_enable=0, no frame is stored and no frame or line event is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Block enable |
| cap_req | input | 1 | Pulse: arm capture |
| cap_clr | input | 1 | Pulse: disarm capture |
| cfg_snapshot | input | 1 | 1 single-frame mode, 0 continuous |
| cfg_pclk_fall | input | 1 | 1 sample on falling pixel clock edge |
| cfg_hs_high | input | 1 | 1 horizontal sync active high |
| cfg_vs_high | input | 1 | 1 vertical sync active high |
| cfg_rate | input | 2 | Frame decimation select |
| cfg_width | input | 2 | Bus width select (8/10/12/14) |
| cfg_crop_en | input | 1 | Crop window enable |
| crop_x | input | CROP_W | First stored column |
| crop_y | input | CROP_W | First stored line |
| crop_w | input | CROP_W | Window width in pixels |
| crop_h | input | CROP_W | Window height in lines |
| pix_clk | input | 1 | Sensor pixel clock |
| pix_hs | input | 1 | Sensor horizontal sync |
| pix_vs | input | 1 | Sensor vertical sync |
| pix_d | input | PIX_W | Sensor pixel data |
| rd_en | input | 1 | Pop the oldest FIFO word |
| rd_data | output | 32 | Oldest FIFO word |
| fifo_valid | output | 1 | FIFO holds data |
| capture_on | output | 1 | Capture armed |
| stat_hs | output | 1 | Horizontal sync currently active |
| stat_vs | output | 1 | Vertical sync currently active |
| irq_en | input | 4 | Per-flag interrupt enable |
| flag_clr | input | 4 | Write-one clear of flags |
| flags | output | 4 | Sticky event flags |
| irq | output | 1 | Masked interrupt |

## Verification
Pins pass one register before use. Sync status therefore follows a pin one clk edge later, an event flag is set two edges after the sampling pixel clock transition, and a completed word is readable three edges after its last sample. The bench holds every pixel clock phase for four clk cycles and samples only on falling clk edges, well after those windows. The driver pushes each expected word into the scoreboard before the sample that completes it is taken. Flag and status checks are made only after a whole frame or an idle gap of several cycles.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    PW_8  = 2'd0,
    PW_10 = 2'd1,
    PW_12 = 2'd2,
    PW_14 = 2'd3
  } pix_width_e;

  typedef enum logic [1:0] {
    FR_ALL     = 2'd0,
    FR_HALF    = 2'd1,
    FR_QUARTER = 2'd2,
    FR_ALL_ALT = 2'd3
  } frame_rate_e;

  localparam int unsigned FLG_EOF = 0;
  localparam int unsigned FLG_EOL = 1;
  localparam int unsigned FLG_VS  = 2;
  localparam int unsigned FLG_OVR = 3;
endpackage

// File: rtl/cam_sample.sv
module cam_sample #(
  parameter int unsigned PIX_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_clk,
  input  logic             pix_hs,
  input  logic             pix_vs,
  input  logic [PIX_W-1:0] pix_d,
  input  logic             cfg_fall,
  input  logic             cfg_hs_high,
  input  logic             cfg_vs_high,
  output logic             strobe,
  output logic             hs_act,
  output logic             vs_act,
  output logic [PIX_W-1:0] smp_d
);
  logic             pclk_q, pclk_d;
  logic             hs_q, vs_q;
  logic [PIX_W-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q <= 1'b0;
      pclk_d <= 1'b0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      d_q    <= '0;
    end else begin
      pclk_q <= pix_clk;
      pclk_d <= pclk_q;
      hs_q   <= pix_hs;
      vs_q   <= pix_vs;
      d_q    <= pix_d;
    end
  end

  assign strobe = cfg_fall ? (pclk_d & ~pclk_q) : (~pclk_d & pclk_q);
  assign hs_act = ~(hs_q ^ cfg_hs_high);
  assign vs_act = ~(vs_q ^ cfg_vs_high);
  assign smp_d  = d_q;

  AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $stable(cfg_fall)) |=> !strobe); // R1
endmodule

// File: rtl/cam_frame.sv
module cam_frame
  import cam_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          hs_act,
  input  logic          vs_act,
  input  logic          enable,
  input  logic          cap_req,
  input  logic          cap_clr,
  input  logic          snapshot,
  input  logic [1:0]    rate,
  input  logic          crop_en,
  input  logic [CW-1:0] crop_x,
  input  logic [CW-1:0] crop_y,
  input  logic [CW-1:0] crop_w,
  input  logic [CW-1:0] crop_h,
  output logic          pix_keep,
  output logic          sof,
  output logic          ev_eof,
  output logic          ev_eol,
  output logic          ev_vs,
  output logic          capture_on
);
  logic          vs_prev, hs_prev, grab, cap_bit;
  logic          vs_prev_n, hs_prev_n, grab_n, cap_n;
  logic [1:0]    fcnt, fcnt_n;
  logic [CW-1:0] xcnt, ycnt, xcnt_n, ycnt_n;
  logic          fs, fe, le, pv, pick, in_x, in_y;

  assign fs = strobe & vs_prev & ~vs_act;
  assign fe = strobe & ~vs_prev & vs_act;
  assign le = strobe & ~hs_prev & hs_act & ~vs_act;
  assign pv = strobe & ~hs_act & ~vs_act;

  always_comb begin
    unique case (frame_rate_e'(rate))
      FR_HALF:    pick = ~fcnt[0];
      FR_QUARTER: pick = (fcnt == 2'd0);
      default:    pick = 1'b1;
    endcase
  end

  assign in_x = ({1'b0, xcnt} >= {1'b0, crop_x}) &&
                ({1'b0, xcnt} <  ({1'b0, crop_x} + {1'b0, crop_w}));
  assign in_y = ({1'b0, ycnt} >= {1'b0, crop_y}) &&
                ({1'b0, ycnt} <  ({1'b0, crop_y} + {1'b0, crop_h}));

  always_comb begin
    vs_prev_n = strobe ? vs_act : vs_prev;
    hs_prev_n = strobe ? hs_act : hs_prev;
    cap_n     = cap_bit;
    grab_n    = grab;
    fcnt_n    = fcnt;
    if (fs && enable && cap_bit) begin
      grab_n = pick;
      fcnt_n = fcnt + 2'd1;
    end
    if (fe) begin
      grab_n = 1'b0;
      if (grab && snapshot) cap_n = 1'b0;
    end
    if (!cap_bit) fcnt_n = 2'd0;
    if (!enable)  grab_n = 1'b0;
    if (cap_req)  cap_n  = 1'b1;
    if (cap_clr) begin
      cap_n  = 1'b0;
      grab_n = 1'b0;
    end
  end

  always_comb begin
    xcnt_n = xcnt;
    ycnt_n = ycnt;
    if (fs) begin
      xcnt_n = '0;
      ycnt_n = '0;
    end else if (strobe) begin
      if (hs_act)       xcnt_n = '0;
      else if (!vs_act) xcnt_n = xcnt + CW'(1);
      if (le)           ycnt_n = ycnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_prev <= 1'b1;
      hs_prev <= 1'b1;
      grab    <= 1'b0;
      cap_bit <= 1'b0;
      fcnt    <= 2'd0;
      xcnt    <= '0;
      ycnt    <= '0;
    end else begin
      vs_prev <= vs_prev_n;
      hs_prev <= hs_prev_n;
      grab    <= grab_n;
      cap_bit <= cap_n;
      fcnt    <= fcnt_n;
      xcnt    <= xcnt_n;
      ycnt    <= ycnt_n;
    end
  end

  assign pix_keep   = pv & grab & (~crop_en | (in_x & in_y));
  assign sof        = fs;
  assign ev_vs      = fs & enable;
  assign ev_eof     = fe & grab;
  assign ev_eol     = le & grab;
  assign capture_on = cap_bit;

  AST_START_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grab) |-> $past(fs)); // R3
  AST_SNAPSHOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && grab && snapshot && !cap_req) |=> !cap_bit); // R5
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !grab); // R14
endmodule

// File: rtl/cam_pack.sv
module cam_pack
  import cam_pkg::*;
#(
  parameter int unsigned PIX_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             keep,
  input  logic             sof,
  input  logic [1:0]       width,
  input  logic [PIX_W-1:0] pix_d,
  output logic             word_vld,
  output logic [31:0]      word
);
  logic [31:0] acc, acc_n, word_n;
  logic [1:0]  idx, idx_n;
  logic        vld_n, narrow, last;
  logic [4:0]  nbits;
  logic [15:0] msk, s16;

  assign narrow = (pix_width_e'(width) == PW_8);
  assign nbits  = 5'd8 + {2'b00, width, 1'b0};
  assign msk    = 16'((17'd1 << nbits) - 17'd1);
  assign s16    = 16'(pix_d) & msk;
  assign last   = narrow ? (idx == 2'd3) : idx[0];

  always_comb begin
    acc_n  = acc;
    idx_n  = idx;
    word_n = word;
    vld_n  = 1'b0;
    if (sof) begin
      acc_n = '0;
      idx_n = 2'd0;
    end else if (keep) begin
      if (narrow) acc_n[{idx, 3'b000} +: 8]  = pix_d[7:0];
      else        acc_n[{idx[0], 4'h0} +: 16] = s16;
      if (last) begin
        vld_n  = 1'b1;
        word_n = acc_n;
        acc_n  = '0;
        idx_n  = 2'd0;
      end else begin
        idx_n = idx + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      idx      <= 2'd0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      acc      <= acc_n;
      idx      <= idx_n;
      word     <= word_n;
      word_vld <= vld_n;
    end
  end

  AST_WORD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld); // R7
endmodule

// File: rtl/cam_fifo.sv
module cam_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          valid,
  output logic          ovr
);
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wp, rp, wp_n, rp_n;
  logic [CNTW-1:0] cnt, cnt_n;
  logic            full, empty, do_push, do_pop;

  assign full    = (cnt == CNTW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign ovr     = push & full;

  always_comb begin
    wp_n  = wp;
    rp_n  = rp;
    if (do_push) wp_n = (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
    if (do_pop)  rp_n = (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
    cnt_n = cnt + CNTW'(do_push) - CNTW'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
    end
  end

  assign rdata = mem[rp];
  assign valid = ~empty;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt)); // R11
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(DEPTH)); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt == '0)); // R10
endmodule

// File: rtl/cam_capture.sv
module cam_capture
  import cam_pkg::*;
#(
  parameter int unsigned PIX_W      = 14,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned CROP_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cap_req,
  input  logic              cap_clr,
  input  logic              cfg_snapshot,
  input  logic              cfg_pclk_fall,
  input  logic              cfg_hs_high,
  input  logic              cfg_vs_high,
  input  logic [1:0]        cfg_rate,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_crop_en,
  input  logic [CROP_W-1:0] crop_x,
  input  logic [CROP_W-1:0] crop_y,
  input  logic [CROP_W-1:0] crop_w,
  input  logic [CROP_W-1:0] crop_h,
  input  logic              pix_clk,
  input  logic              pix_hs,
  input  logic              pix_vs,
  input  logic [PIX_W-1:0]  pix_d,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic              fifo_valid,
  output logic              capture_on,
  output logic              stat_hs,
  output logic              stat_vs,
  input  logic [3:0]        irq_en,
  input  logic [3:0]        flag_clr,
  output logic [3:0]        flags,
  output logic              irq
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic             strobe, hs_act, vs_act, keep, sof;
  logic             ev_eof, ev_eol, ev_vs, ovr, word_vld;
  logic [PIX_W-1:0] smp_d;
  logic [31:0]      word;
  logic [3:0]       ev, flags_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  cam_sample #(.PIX_W(PIX_W)) u_sample (
    .clk(clk), .rst_n(rst_core_n), .pix_clk(pix_clk), .pix_hs(pix_hs),
    .pix_vs(pix_vs), .pix_d(pix_d), .cfg_fall(cfg_pclk_fall),
    .cfg_hs_high(cfg_hs_high), .cfg_vs_high(cfg_vs_high),
    .strobe(strobe), .hs_act(hs_act), .vs_act(vs_act), .smp_d(smp_d)
  );

  cam_frame #(.CW(CROP_W)) u_frame (
    .clk(clk), .rst_n(rst_core_n), .strobe(strobe), .hs_act(hs_act),
    .vs_act(vs_act), .enable(cfg_enable), .cap_req(cap_req),
    .cap_clr(cap_clr), .snapshot(cfg_snapshot), .rate(cfg_rate),
    .crop_en(cfg_crop_en), .crop_x(crop_x), .crop_y(crop_y),
    .crop_w(crop_w), .crop_h(crop_h), .pix_keep(keep), .sof(sof),
    .ev_eof(ev_eof), .ev_eol(ev_eol), .ev_vs(ev_vs), .capture_on(capture_on)
  );

  cam_pack #(.PIX_W(PIX_W)) u_pack (
    .clk(clk), .rst_n(rst_core_n), .keep(keep), .sof(sof),
    .width(cfg_width), .pix_d(smp_d), .word_vld(word_vld), .word(word)
  );

  cam_fifo #(.DEPTH(FIFO_DEPTH), .DW(32)) u_fifo (
    .clk(clk), .rst_n(rst_core_n), .push(word_vld), .wdata(word),
    .pop(rd_en), .rdata(rd_data), .valid(fifo_valid), .ovr(ovr)
  );

  always_comb begin
    ev          = '0;
    ev[FLG_EOF] = ev_eof;
    ev[FLG_EOL] = ev_eol;
    ev[FLG_VS]  = ev_vs;
    ev[FLG_OVR] = ovr;
    flags_n     = (flags & ~flag_clr) | ev;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) flags <= '0;
    else             flags <= flags_n;
  end

  assign irq     = |(flags & irq_en);
  assign stat_hs = hs_act;
  assign stat_vs = vs_act;

  for (genvar i = 0; i < 4; i++) begin : g_flag_chk
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_core_n)
      (flag_clr[i] && !ev[i]) |=> !flags[i]); // R12
    AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_core_n)
      (flags[i] && !flag_clr[i]) |=> flags[i]); // R12
  end
endmodule

// File: tb/cam_capture_tb.sv
`timescale 1ns/1ps
module cam_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cap_req = 1'b0, cap_clr = 1'b0;
  logic        cfg_snapshot = 1'b0, cfg_pclk_fall = 1'b0;
  logic        cfg_hs_high = 1'b1, cfg_vs_high = 1'b1;
  logic [1:0]  cfg_rate = 2'd0, cfg_width = 2'd0;
  logic        cfg_crop_en = 1'b0;
  logic [15:0] crop_x = '0, crop_y = '0, crop_w = '0, crop_h = '0;
  logic        pix_clk = 1'b0, pix_hs = 1'b1, pix_vs = 1'b1;
  logic [13:0] pix_d = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        fifo_valid, capture_on, stat_hs, stat_vs, irq;
  logic [3:0]  irq_en = '0, flag_clr = '0, flags;

  always #4 clk = ~clk;

  cam_capture dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cap_req(cap_req),
    .cap_clr(cap_clr), .cfg_snapshot(cfg_snapshot), .cfg_pclk_fall(cfg_pclk_fall),
    .cfg_hs_high(cfg_hs_high), .cfg_vs_high(cfg_vs_high), .cfg_rate(cfg_rate),
    .cfg_width(cfg_width), .cfg_crop_en(cfg_crop_en), .crop_x(crop_x),
    .crop_y(crop_y), .crop_w(crop_w), .crop_h(crop_h), .pix_clk(pix_clk),
    .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_d(pix_d), .rd_en(rd_en),
    .rd_data(rd_data), .fifo_valid(fifo_valid), .capture_on(capture_on),
    .stat_hs(stat_hs), .stat_vs(stat_vs), .irq_en(irq_en),
    .flag_clr(flag_clr), .flags(flags), .irq(irq)
  );

  int          checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  logic [31:0] exp_acc;
  int          exp_idx, pushed, push_cap = -1;
  bit          drain = 1'b1, drv_fall = 1'b0, wrong_edge = 1'b0;
  bit          hs_hi = 1'b1, vs_hi = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pop and compare each word the FIFO presents (R10)
  always @(negedge clk) begin
    rd_en = 1'b0;
    if (drain && fifo_valid && rst_n) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected word", rd_data, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R10 word", rd_data, e);
      end
      rd_en = 1'b1;
    end
  end

  task automatic pulse_req();
    cap_req = 1'b1; @(negedge clk); cap_req = 1'b0;
  endtask
  task automatic pulse_clr();
    cap_clr = 1'b1; @(negedge clk); cap_clr = 1'b0;
  endtask
  task automatic clear_flags();
    flag_clr = 4'hF; @(negedge clk); flag_clr = 4'h0; @(negedge clk);
  endtask

  // One pixel clock period; data is spoiled around the non-sampling edge
  task automatic px(input logic [13:0] d, input bit hs_on, input bit vs_on);
    pix_hs = hs_on ? hs_hi : ~hs_hi;
    pix_vs = vs_on ? vs_hi : ~vs_hi;
    pix_d  = d;
    repeat (4) @(negedge clk);
    pix_clk = ~drv_fall;
    repeat (4) @(negedge clk);
    pix_clk = drv_fall;
    pix_d   = ~d;
    repeat (4) @(negedge clk);
  endtask

  task automatic model_px(input int x, input int y, input logic [13:0] v);
    logic [13:0] s;
    logic [15:0] m;
    if (cfg_crop_en && !(x >= crop_x && x < crop_x + crop_w &&
                         y >= crop_y && y < crop_y + crop_h)) return;
    s = wrong_edge ? ~v : v;
    if (cfg_width == 2'd0) begin
      exp_acc[exp_idx*8 +: 8] = s[7:0];
      if (exp_idx == 3) exp_idx = 4; else exp_idx++;
    end else begin
      m = 16'((17'd1 << (8 + 2*cfg_width)) - 1);
      exp_acc[exp_idx*16 +: 16] = {2'b00, s} & m;
      if (exp_idx == 1) exp_idx = 4; else exp_idx++;
    end
    if (exp_idx == 4) begin
      if (push_cap < 0 || pushed < push_cap) exp_q.push_back(exp_acc);
      pushed++;
      exp_acc = '0;
      exp_idx = 0;
    end
  endtask

  task automatic send_frame(input int lines, input int ppl, input int base,
                            input bit exp, input bit mid_req);
    px(14'd0, 1, 1); px(14'd0, 1, 1);
    exp_acc = '0; exp_idx = 0; pushed = 0;
    for (int l = 0; l < lines; l++) begin
      px(14'd0, 1, 0); px(14'd0, 1, 0);
      if (mid_req && l == 1) pulse_req();
      for (int i = 0; i < ppl; i++) begin
        logic [13:0] v;
        v = 14'(base + l*ppl + i);
        if (exp) model_px(i, l, v);
        px(v, 0, 0);
      end
    end
    px(14'd0, 1, 0);
    px(14'd0, 1, 1);
  endtask

  task automatic settle(input string req);
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(fifo_valid == 0, "R10 reset fifo", fifo_valid, 0);
    chk(flags == 0 && irq == 0, "R12 reset flags", flags, 0);
    chk(capture_on == 0, "R3 reset capture", capture_on, 0);

    // R4 R7 R12 R13: continuous 8-bit capture
    cfg_enable = 1; irq_en = 4'b0001;
    pulse_req();
    send_frame(2, 8, 8'h10, 1, 0);
    send_frame(2, 8, 8'h40, 1, 0);
    settle("R7 all words arrived");
    chk(capture_on == 1, "R4 still armed", capture_on, 1);
    chk(flags == 4'b0111, "R12 events", flags, 4'b0111);
    chk(irq == 1, "R13 irq on", irq, 1);
    irq_en = 4'b1000; @(negedge clk);
    chk(irq == 0, "R13 irq masked", irq, 0);
    clear_flags();
    chk(flags == 0, "R12 write-one clear", flags, 0);

    // R3: arm in the middle of a frame
    pulse_clr();
    send_frame(3, 4, 8'h80, 0, 1);
    send_frame(2, 4, 8'hA0, 1, 0);
    settle("R3 only next frame");

    // R8: 10-bit packing with masking
    cfg_width = 2'd1;
    send_frame(1, 6, 14'h3F00, 1, 0);
    settle("R8 10-bit words");
    cfg_width = 2'd3;
    send_frame(1, 4, 14'h3FF0, 1, 0);
    settle("R8 14-bit words");
    cfg_width = 2'd0;

    // R9: crop window
    cfg_crop_en = 1; crop_x = 2; crop_w = 4; crop_y = 1; crop_h = 1;
    send_frame(3, 8, 8'h20, 1, 0);
    settle("R9 crop");
    cfg_crop_en = 0;

    // R6: decimation 1/2 then 1/4
    pulse_clr(); cfg_rate = 2'd1; pulse_req();
    send_frame(1, 4, 8'h00, 1, 0);
    send_frame(1, 4, 8'h10, 0, 0);
    send_frame(1, 4, 8'h20, 1, 0);
    send_frame(1, 4, 8'h30, 0, 0);
    settle("R6 half rate");
    pulse_clr(); cfg_rate = 2'd2; pulse_req();
    send_frame(1, 4, 8'h40, 1, 0);
    send_frame(1, 4, 8'h50, 0, 0);
    send_frame(1, 4, 8'h60, 0, 0);
    send_frame(1, 4, 8'h70, 0, 0);
    send_frame(1, 4, 8'h80, 1, 0);
    settle("R6 quarter rate");
    cfg_rate = 2'd0;

    // R5: snapshot
    pulse_clr(); cfg_snapshot = 1; pulse_req();
    send_frame(1, 8, 8'h90, 1, 0);
    chk(capture_on == 0, "R5 self clear", capture_on, 0);
    send_frame(1, 8, 8'hB0, 0, 0);
    settle("R5 one frame only");
    cfg_snapshot = 0;

    // R1 R2: falling edge with active-low syncs
    hs_hi = 0; vs_hi = 0; cfg_hs_high = 0; cfg_vs_high = 0;
    pix_hs = 0; pix_vs = 0; drv_fall = 1; pix_clk = 1;
    repeat (4) @(negedge clk);
    cfg_pclk_fall = 1;
    pulse_req();
    send_frame(1, 8, 8'hC0, 1, 0);
    settle("R1 falling edge data");
    chk(stat_vs == 1 && stat_hs == 1, "R2 active low status", {stat_hs, stat_vs}, 3);
    pix_hs = 1; pix_vs = 1; repeat (3) @(negedge clk);
    chk(stat_vs == 0 && stat_hs == 0, "R2 inactive status", {stat_hs, stat_vs}, 0);
    pix_hs = 0; pix_vs = 0; repeat (3) @(negedge clk);
    // R1: rising-edge setting sees only the spoiled data
    cfg_pclk_fall = 0; wrong_edge = 1;
    send_frame(1, 8, 8'hD0, 1, 0);
    settle("R1 other edge ignored");
    wrong_edge = 0;
    hs_hi = 1; vs_hi = 1; cfg_hs_high = 1; cfg_vs_high = 1;
    pix_hs = 1; pix_vs = 1; drv_fall = 0; pix_clk = 0;
    repeat (4) @(negedge clk);

    // R11: overrun keeps the first FIFO_DEPTH words
    clear_flags();
    drain = 0; push_cap = 8;
    send_frame(1, 48, 8'h00, 1, 0);
    chk(flags[3] == 1, "R11 overrun flag", flags[3], 1);
    chk(fifo_valid == 1, "R11 data kept", fifo_valid, 1);
    drain = 1;
    settle("R11 kept words");
    push_cap = -1;
    clear_flags();

    // R14: disabled block stores and flags nothing
    cfg_enable = 0;
    send_frame(1, 8, 8'h55, 0, 0);
    settle("R14 nothing stored");
    chk(flags == 0, "R14 no events", flags, 0);
    chk(fifo_valid == 0, "R14 fifo empty", fifo_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule